// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Word Buffer

This block recovers asynchronous serial frames from a single receive line. The line is sampled at sixteen times the bit rate, with one enable pulse per sample supplied from outside. A frame starts with a low start bit. Data bits follow least significant bit first, 8 or 9 of them, then an optional parity bit and a high stop bit. The value of every bit is the majority of three samples taken around the middle of the bit period. When the three samples disagree, the frame is marked as noisy.

Finished words go into a two-entry first-in first-out buffer. A third word can be shifted in while both entries are held. If that third word completes while the buffer is still full and no read happens in the same cycle, the word is dropped and an overrun flag is raised. The host sees the oldest word, its ninth bit, a data-available flag and a one-cycle interrupt pulse for each word that is accepted. Four sticky error flags (framing, noise, parity, overrun) stay set until a status access is followed by a data read.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `data_avail`, `irq` and all four error flags are 0.
- R2: With `cfg_nine`=0, eight data bits received LSB first appear on `rd_data`, and `rd_bit8` reads 0.
- R3: With `cfg_nine`=1, nine data bits are received, and the ninth bit received (the last data bit) appears on `rd_bit8`.
- R4: Each bit is decided by a majority of the samples at oversample counts 7, 8 and 9 of its period. One sample that disagrees with the other two does not change the bit, and it sets `err_noise`.
- R5: A falling edge whose start bit votes high at mid-bit is a false start: no word is stored, and the receiver returns to idle and waits for the next falling edge.
- R6: A stop bit that votes low sets `err_frame`, and the word is still stored.
- R7: With `cfg_par_en`=1, one parity bit follows the data bits. It makes the count of ones even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets `err_parity`.
- R8: The buffer holds up to two words and returns them in arrival order. A `data_rd` pulse removes the oldest word. `data_avail` is 1 exactly while at least one word is held.
- R9: A word that completes while both entries are full and no `data_rd` is present is discarded and sets `err_overrun`. If `data_rd` arrives in the same cycle, the word is accepted and no overrun is flagged.
- R10: `irq` pulses high for one cycle for each accepted word while `irq_en`=1. It stays low for discarded words and while `irq_en`=0.
- R11: Error flags are sticky. They clear only on a `data_rd` that follows a `stat_rd` pulse. A `data_rd` with no `stat_rd` before it leaves them set.
- R12: A `data_rd` while the buffer is empty has no effect on `data_avail` or on the words later received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| irq_en | input | 1 | Enables the interrupt pulse |
| stat_rd | input | 1 | Status access strobe, arms the flag clear |
| data_rd | input | 1 | Data read strobe, removes the oldest word |
| rd_data | output | 8 | Low eight bits of the oldest word |
| rd_bit8 | output | 1 | Ninth bit of the oldest word |
| data_avail | output | 1 | Buffer holds at least one word |
| irq | output | 1 | One-cycle pulse per accepted word |
| err_frame | output | 1 | Sticky framing error |
| err_noise | output | 1 | Sticky noise error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
Two events can fall in the same cycle: a word completing into the buffer and a host read removing the oldest word. The bench first fills both entries. It then times a `data_rd` pulse to land on the exact cycle in which a third word is pushed. That third word must be accepted, with an interrupt pulse and no overrun, and the buffer must then read out the second and third words in order. A fourth word sent with no read must then be dropped, with the overrun flag set and no interrupt pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int CNT_W = 4,
  parameter int MID   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_tick,
  input  logic             sample_in,
  input  logic [CNT_W-1:0] cnt,
  output logic             decide,
  output logic             bit_val,
  output logic             bit_noisy
);
  localparam logic [CNT_W-1:0] C_FIRST  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] C_SECOND = CNT_W'(MID);
  localparam logic [CNT_W-1:0] C_THIRD  = CNT_W'(MID + 1);

  logic s_a, s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (os_tick) begin
      if (cnt == C_FIRST)  s_a <= sample_in;
      if (cnt == C_SECOND) s_b <= sample_in;
    end
  end

  always_comb begin
    decide    = os_tick && (cnt == C_THIRD);
    bit_val   = (s_a & s_b) | (s_a & sample_in) | (s_b & sample_in);
    bit_noisy = !((s_a == s_b) && (s_b == sample_in));
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int MID     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            os_tick,
  input  logic            rx_s,
  input  logic            cfg_nine,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  output logic            done,
  output logic [DATA_W:0] word,
  output logic            f_frame,
  output logic            f_noise,
  output logic            f_parity
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_last;
  logic [DATA_W:0]  sh;
  logic             rx_prev;
  logic             noise_acc;
  logic             par_acc;
  logic             decide, bit_val, bit_noisy;

  uart_rx_vote #(.CNT_W(CNT_W), .MID(MID)) u_vote (
    .clk       (clk),
    .rst       (rst),
    .os_tick   (os_tick),
    .sample_in (rx_s),
    .cnt       (cnt),
    .decide    (decide),
    .bit_val   (bit_val),
    .bit_noisy (bit_noisy)
  );

  assign idx_last = cfg_nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      rx_prev   <= 1'b1;
      noise_acc <= 1'b0;
      par_acc   <= 1'b0;
      done      <= 1'b0;
      word      <= '0;
      f_frame   <= 1'b0;
      f_noise   <= 1'b0;
      f_parity  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (os_tick) rx_prev <= rx_s;
      if (state == ST_IDLE) begin
        if (os_tick && rx_prev && !rx_s) begin
          state     <= ST_START;
          cnt       <= '0;
          idx       <= '0;
          noise_acc <= 1'b0;
          par_acc   <= 1'b0;
        end
      end else begin
        if (os_tick) cnt <= (cnt == CNT_LAST) ? '0 : cnt + CNT_W'(1);
        if (decide) begin
          case (state)
            ST_START: begin
              if (bit_val) state <= ST_IDLE;
              noise_acc <= bit_noisy;
            end
            ST_DATA: begin
              sh        <= {bit_val, sh[DATA_W:1]};
              par_acc   <= par_acc ^ bit_val;
              noise_acc <= noise_acc | bit_noisy;
              idx       <= idx + IDX_W'(1);
              if (idx == idx_last) state <= cfg_par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR: begin
              par_acc   <= par_acc ^ bit_val;
              noise_acc <= noise_acc | bit_noisy;
              state     <= ST_STOP;
            end
            ST_STOP: begin
              done     <= 1'b1;
              word     <= cfg_nine ? sh : {1'b0, sh[DATA_W:1]};
              f_frame  <= !bit_val;
              f_noise  <= noise_acc | bit_noisy;
              f_parity <= cfg_par_en && (par_acc != cfg_par_odd);
              state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
          if (state == ST_START && !bit_val) state <= ST_DATA;
        end
      end
    end
  end

  AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && decide && bit_val) |=> (state == ST_IDLE)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [WIDTH-1:0]   din,
  input  logic               pop,
  output logic [WIDTH-1:0]   dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic               push_ok,
  output logic               overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_pop;

  always_comb begin
    do_pop  = pop && (count != '0);
    push_ok = push && ((count != CNT_FULL) || do_pop);
    overrun = push && !push_ok;
    dout    = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + PTR_W'(1);
      if (do_pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + PTR_W'(1);
      case ({push_ok, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && count == CNT_FULL && !pop) |=> (count == CNT_FULL)); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !push) |=> (count == '0)); // R12
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int MID     = 8,
  parameter int DEPTH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit8,
  output logic              data_avail,
  output logic              irq,
  output logic              err_frame,
  output logic              err_noise,
  output logic              err_parity,
  output logic              err_overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              rx_m, rx_s;
  logic              done;
  logic [DATA_W:0]   word, head;
  logic              f_frame, f_noise, f_parity;
  logic [CNT_W-1:0]  count;
  logic              push_ok, overrun;
  logic              clr_arm, clr_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .MID(MID)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .os_tick     (os_tick),
    .rx_s        (rx_s),
    .cfg_nine    (cfg_nine),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .done        (done),
    .word        (word),
    .f_frame     (f_frame),
    .f_noise     (f_noise),
    .f_parity    (f_parity)
  );

  uart_rx_buf #(.WIDTH(DATA_W + 1), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .push    (done),
    .din     (word),
    .pop     (data_rd),
    .dout    (head),
    .count   (count),
    .push_ok (push_ok),
    .overrun (overrun)
  );

  assign rd_data    = head[DATA_W-1:0];
  assign rd_bit8    = head[DATA_W];
  assign data_avail = (count != '0);
  assign clr_fire   = data_rd && clr_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_arm     <= 1'b0;
      irq         <= 1'b0;
      err_frame   <= 1'b0;
      err_noise   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (stat_rd)      clr_arm <= 1'b1;
      else if (data_rd) clr_arm <= 1'b0;
      irq         <= irq_en && push_ok;
      err_frame   <= (err_frame   && !clr_fire) || (done && f_frame);
      err_noise   <= (err_noise   && !clr_fire) || (done && f_noise);
      err_parity  <= (err_parity  && !clr_fire) || (done && f_parity);
      err_overrun <= (err_overrun && !clr_fire) || overrun;
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R10
  AST_IRQ_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    irq |-> data_avail); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !data_rd) |=> err_overrun); // R11
endmodule

// File: tb/uart_rx_fifo_tb.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b1;
  logic rx_in = 1'b1;
  logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic irq_en = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_bit8, data_avail, irq;
  logic err_frame, err_noise, err_parity, err_overrun;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_rx_fifo u_dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .irq_en(irq_en), .stat_rd(stat_rd), .data_rd(data_rd),
    .rd_data(rd_data), .rd_bit8(rd_bit8), .data_avail(data_avail), .irq(irq),
    .err_frame(err_frame), .err_noise(err_noise), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // gl: frame bit index that gets a one-clock glitch (0 = start bit), -1 none
  task automatic send(input logic [8:0] w, input bit nine, input bit pe, input bit po,
                      input int gl, input bit bad_par, input bit bad_stop,
                      input bit rd_at_done, output bit irq_seen);
    logic [11:0] bits;
    int n;
    int nb;
    logic p;
    nb = nine ? 9 : 8;
    p = nine ? ^w : ^w[7:0];
    if (po) p = ~p;
    if (bad_par) p = ~p;
    bits = '0;
    n = 1;
    for (int i = 0; i < nb; i++) begin bits[n] = w[i]; n++; end
    if (pe) begin bits[n] = p; n++; end
    bits[n] = !bad_stop;
    n++;
    irq_seen = 1'b0;
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        if (b == n - 1 && c == 14) irq_seen = irq;
        rx_in   = (b == gl && c == 9) ? ~bits[b] : bits[b];
        data_rd = rd_at_done && (b == n - 1) && (c == 13);
      end
    end
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      rx_in = 1'b1;
      data_rd = 1'b0;
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic clear_all();
    pulse_stat();
    pulse_rd();
  endtask

  initial begin
    bit iq;
    int any_bad;
    logic [8:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!data_avail && !irq, "R1 avail/irq", {data_avail, irq}, 0);
    check({err_frame, err_noise, err_parity, err_overrun} == 4'b0, "R1 flags",
          {err_frame, err_noise, err_parity, err_overrun}, 0);

    // R2: all byte values, 8-bit mode, no parity
    for (int i = 0; i < 256; i++) begin
      send(9'(i), 0, 0, 0, -1, 0, 0, 0, iq);
      check(data_avail && rd_data == 8'(i) && !rd_bit8, "R2 byte",
            {rd_bit8, rd_data}, i);
      pulse_rd();
      check(!data_avail, "R8 empty after read", data_avail, 0);
    end
    check({err_frame, err_noise, err_parity, err_overrun} == 4'b0, "R2 no flags",
          {err_frame, err_noise, err_parity, err_overrun}, 0);

    // R3 / R7: nine-bit words with parity of both senses
    cfg_nine = 1'b1; cfg_par_en = 1'b1;
    any_bad = 0;
    for (int i = 0; i < 128; i++) begin
      v = 9'((i * 37 + 5) % 512);
      cfg_par_odd = i[0];
      send(v, 1, 1, i[0], -1, 0, 0, 0, iq);
      check(rd_data == v[7:0] && rd_bit8 == v[8], "R3 nine-bit word",
            {rd_bit8, rd_data}, v);
      if (err_parity) any_bad++;
      pulse_rd();
    end
    check(any_bad == 0, "R7 good parity", any_bad, 0);

    // R7: wrong parity bit
    cfg_par_odd = 1'b0;
    send(9'h1A5, 1, 1, 0, -1, 1, 0, 0, iq);
    check(err_parity, "R7 parity error", err_parity, 1);
    check(rd_data == 8'hA5 && rd_bit8, "R7 word kept", {rd_bit8, rd_data}, 9'h1A5);
    clear_all();
    check(!err_parity && !data_avail, "R11 parity cleared", {err_parity, data_avail}, 0);

    // R4: one-sample glitch on data bit 3
    cfg_nine = 1'b0; cfg_par_en = 1'b0;
    send(9'h03C, 0, 0, 0, 4, 0, 0, 0, iq);
    check(rd_data == 8'h3C, "R4 vote keeps bit", rd_data, 8'h3C);
    check(err_noise, "R4 noise flag", err_noise, 1);
    pulse_rd();
    check(err_noise, "R11 read alone keeps flag", err_noise, 0 + 1);
    pulse_rd();
    check(!data_avail, "R12 read on empty", data_avail, 0);
    pulse_stat();
    pulse_rd();
    check(!err_noise, "R11 stat then read clears", err_noise, 0);

    // R12: empty read did not disturb the next word
    send(9'h05A, 0, 0, 0, -1, 0, 0, 0, iq);
    check(data_avail && rd_data == 8'h5A, "R12 next word", rd_data, 8'h5A);
    pulse_rd();

    // R5: false start, then a real word
    @(negedge clk); rx_in = 1'b0;
    repeat (5) @(negedge clk);
    rx_in = 1'b1;
    repeat (200) @(negedge clk);
    check(!data_avail, "R5 false start stores nothing", data_avail, 0);
    send(9'h0C3, 0, 0, 0, -1, 0, 0, 0, iq);
    check(data_avail && rd_data == 8'hC3, "R5 word after false start", rd_data, 8'hC3);
    pulse_rd();

    // R6: stop bit low
    send(9'h081, 0, 0, 0, -1, 0, 1, 0, iq);
    check(err_frame, "R6 framing flag", err_frame, 1);
    check(data_avail && rd_data == 8'h81, "R6 word stored", rd_data, 8'h81);
    clear_all();
    check(!err_frame, "R11 frame cleared", err_frame, 0);

    // R8 / R9 / R10: fill, coincident read, then overrun
    irq_en = 1'b1;
    send(9'h011, 0, 0, 0, -1, 0, 0, 0, iq);
    check(iq, "R10 irq on word A", iq, 1);
    send(9'h022, 0, 0, 0, -1, 0, 0, 0, iq);
    check(iq, "R10 irq on word B", iq, 1);
    check(rd_data == 8'h11, "R8 head is A", rd_data, 8'h11);
    send(9'h033, 0, 0, 0, -1, 0, 0, 1, iq);
    check(iq, "R9 coincident read accepts C", iq, 1);
    check(!err_overrun, "R9 no overrun with read", err_overrun, 0);
    send(9'h044, 0, 0, 0, -1, 0, 0, 0, iq);
    check(!iq, "R10 no irq on dropped D", iq, 0);
    check(err_overrun, "R9 overrun flag", err_overrun, 1);
    check(rd_data == 8'h22, "R8 head is B", rd_data, 8'h22);
    pulse_rd();
    check(data_avail && rd_data == 8'h33, "R9 C kept, D dropped", rd_data, 8'h33);
    pulse_stat();
    pulse_rd();
    check(!data_avail, "R8 empty after two", data_avail, 0);
    check(!err_overrun, "R11 overrun cleared", err_overrun, 0);

    // R10: interrupt disabled
    irq_en = 1'b0;
    send(9'h077, 0, 0, 0, -1, 0, 0, 0, iq);
    check(!iq && data_avail, "R10 irq disabled", iq, 0);
    pulse_rd();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule